// File: doc/BRIEF.md
# Two-Tone FSK Period Demodulator

This block turns a digitised two-tone FSK receive signal back into NRZ data. An external band-pass filter and comparator supply the signal as a square wave. The block runs from a 460.8 kHz time base. It resynchronises the comparator bit, times every half-period between consecutive transitions in clock cycles, and sorts each half-period into one of two classes. Half-periods at or above a threshold count as mark (the 1200 Hz tone, nominally 192 counts). Shorter half-periods count as space (the 2200 Hz tone, nominally about 105 counts). The threshold sits between the two at 148 counts.

The latest decision reaches the data output only while carrier detect is high and the local transmitter is idle. The transmitter is idle when request-to-send, which is active low, is high. In every other case the output rests at the idle mark level. While the transmitter is active, the receiver stops measuring and keeps its last decision.

A gap between transitions that fills the half-period counter means there is no usable signal. Such a gap leaves the previous decision unchanged. Both the threshold and the counter width are parameters.

Top module: `fskd_demod`

## Requirements
- R1: After reset the data output is 1, and the held decision is mark.
- R2: A half-period of at least 148 and at most 510 clock cycles sets the decision to mark, so the data output shows 1.
- R3: A half-period of fewer than 148 clock cycles sets the decision to space, so the data output shows 0.
- R4: A half-period is measured between consecutive transitions of either polarity. A gap of 511 cycles or more saturates the 9-bit counter and leaves the decision unchanged.
- R5: While carrier detect is 0, the data output is 1 from the next clock edge on. When carrier detect returns, the output again shows the held decision after one edge.
- R6: While request-to-send is 0, the data output is 1 from the next clock edge on. Input transitions in that time do not change the held decision. The first transition after request-to-send returns to 1 is not used as a measurement.
- R7: A decision reaches the data output on the fifth rising clock edge after the input transition that ends the half-period. It is not visible on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 460.8 kHz demodulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_cmp_i | input | 1 | Comparator square wave from the receive filter, asynchronous |
| carrier_i | input | 1 | Carrier detect, 1 when a valid carrier is present |
| rts_ni | input | 1 | Request-to-send, active low; 0 means transmitting |
| rx_data_o | output | 1 | Recovered NRZ data, 1 when gated off |

## Verification
An input transition passes through the two synchroniser flops and the edge flop before the measurement is registered. The decision follows one edge later, and the output register one edge after that. The decision for a half-period is therefore due on the fifth rising edge. The bench checks that edge exactly for R7. Every other tone check waits six edges after the last transition and samples on a falling edge. Changes in the gating inputs reach the output after a single edge, so those checks sample on the falling edge after the next rising edge. The half-period sweep steps one cycle at a time across the threshold. Before each tone, the bench drives the opposite decision so that a stuck output cannot pass.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  localparam int unsigned DEF_CNT_W  = 9;
  localparam int unsigned DEF_THRESH = 148;
  localparam int unsigned DEF_SYNC   = 2;

  typedef enum logic {
    SPACE = 1'b0,
    MARK  = 1'b1
  } fsk_bit_e;
endpackage

// File: rtl/fskd_sync.sv
module fskd_sync #(
  parameter int unsigned STAGES = fskd_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  // stage 0..STAGES-1 resynchronise, stage STAGES holds previous level
  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/fskd_period.sv
module fskd_period #(
  parameter int unsigned CNT_W = fskd_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             edge_i,
  output logic             meas_v_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_MAX;
      meas_o   <= '0;
      meas_v_o <= 1'b0;
    end else if (!run_i) begin
      // receiver parked: next edge measures as saturated
      cnt_q    <= CNT_MAX;
      meas_v_o <= 1'b0;
    end else if (edge_i) begin
      meas_o   <= cnt_q;
      meas_v_o <= 1'b1;
      cnt_q    <= CNT_ONE;
    end else begin
      meas_v_o <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    end
  end
endmodule

// File: rtl/fskd_slicer.sv
module fskd_slicer #(
  parameter int unsigned CNT_W  = fskd_pkg::DEF_CNT_W,
  parameter int unsigned THRESH = fskd_pkg::DEF_THRESH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               meas_v_i,
  input  logic [CNT_W-1:0]   meas_i,
  output fskd_pkg::fsk_bit_e bit_o
);
  import fskd_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] THR     = CNT_W'(THRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              bit_o <= MARK;
    else if (meas_v_i && meas_i != CNT_MAX)   bit_o <= (meas_i >= THR) ? MARK : SPACE;
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_v_i && meas_i == CNT_MAX) |=> $stable(bit_o));
  // R2
  mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_v_i && meas_i >= THR && meas_i != CNT_MAX) |=> (bit_o == MARK));
  // R3
  space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_v_i && meas_i < THR) |=> (bit_o == SPACE));
endmodule

// File: rtl/fskd_demod.sv
module fskd_demod #(
  parameter int unsigned CNT_W  = fskd_pkg::DEF_CNT_W,
  parameter int unsigned THRESH = fskd_pkg::DEF_THRESH,
  parameter int unsigned SYNC   = fskd_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_cmp_i,
  input  logic carrier_i,
  input  logic rts_ni,
  output logic rx_data_o
);
  import fskd_pkg::*;

  logic             edge_w;
  logic             meas_v_w;
  logic [CNT_W-1:0] meas_w;
  fsk_bit_e         bit_w;
  logic             rx_en_w;

  assign rx_en_w = rts_ni & carrier_i;

  fskd_sync #(.STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_cmp_i),
    .edge_o (edge_w)
  );

  fskd_period #(.CNT_W(CNT_W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (rts_ni),
    .edge_i   (edge_w),
    .meas_v_o (meas_v_w),
    .meas_o   (meas_w)
  );

  fskd_slicer #(.CNT_W(CNT_W), .THRESH(THRESH)) u_slicer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .meas_v_i (meas_v_w),
    .meas_i   (meas_w),
    .bit_o    (bit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_data_o <= 1'b1;
    else         rx_data_o <= rx_en_w ? bit_w : MARK;
  end

  // R5
  idle_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_i |=> rx_data_o);
  // R6
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_ni |=> rx_data_o);
endmodule

// File: tb/tb_fskd_demod.sv
module tb_fskd_demod;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx = 1'b0;
  logic car = 1'b1;
  logic rts = 1'b1;
  logic dout;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  fskd_demod dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .rx_cmp_i  (rx),
    .carrier_i (car),
    .rts_ni    (rts),
    .rx_data_o (dout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rx_data_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // n transitions, each h rising edges after the previous one
  task automatic tone(input int h, input int n);
    for (int i = 0; i < n; i++) begin
      repeat (h) @(posedge clk);
      #1 rx = ~rx;
    end
  endtask

  // 6 edges then sample away from the edge
  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset", dout, 1'b1);
    settle();
    chk("R1 idle mark", dout, 1'b1);

    // R2/R3 sweep across threshold, opposite decision driven first
    for (int h = 96; h <= 200; h++) begin
      if (h >= 148) tone(104, 3);
      else          tone(192, 3);
      tone(h, 3);
      settle();
      chk(h >= 148 ? "R2 mark half-period" : "R3 space half-period", dout, (h >= 148));
    end

    // R4 longest valid gap: 6 settle edges + 504 = 510
    tone(104, 3);
    settle();
    chk("R3 space before gap", dout, 1'b0);
    tone(504, 1);
    settle();
    chk("R4 gap 510 is mark", dout, 1'b1);
    // R4 saturated gap: 6 + 505 = 511, ignored
    tone(104, 3);
    settle();
    tone(505, 1);
    settle();
    chk("R4 gap 511 ignored", dout, 1'b0);
    tone(900, 1);
    settle();
    chk("R4 long gap ignored", dout, 1'b0);

    // R7 latency: mark held, then a 100-edge half-period ends
    tone(192, 3);
    settle();
    chk("R2 mark before latency", dout, 1'b1);
    tone(94, 1);                       // 6 + 94 = 100 -> space
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7 not on fourth edge", dout, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R7 on fifth edge", dout, 1'b0);

    // R5 carrier gating
    settle();
    #1 car = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R5 carrier off idle", dout, 1'b1);
    tone(104, 3);
    settle();
    chk("R5 carrier off still idle", dout, 1'b1);
    car = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R5 carrier back shows space", dout, 1'b0);

    // R6 transmit: output idle, edges ignored, first edge after resume ignored
    rts = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 transmit idle", dout, 1'b1);
    tone(192, 4);
    settle();
    chk("R6 transmit still idle", dout, 1'b1);
    rts = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R6 decision kept", dout, 1'b0);
    tone(192, 1);
    settle();
    chk("R6 first edge ignored", dout, 1'b0);
    tone(186, 1);                      // 6 + 186 = 192
    settle();
    chk("R6 receive resumes", dout, 1'b1);

    done = 1'b1;
    summary();
  end
endmodule